// File: doc/BRIEF.md
# DRAM Access Cycle Timing Sequencer

This block steps through the RAS/CAS strobe pattern of one DRAM transfer or one refresh at a time. The shape of every cycle comes from a single 8-bit control register. One field sets how many states the row strobe stays in precharge before a cycle. A second field sets how many wait states separate the row strobe from the column strobe. A flag adds one idle state when a non-DRAM bus access comes straight after a DRAM read. The same precharge length serves both ordinary transfers and refresh.

A bus master offers a request as a one-cycle pulse while `busy` is low. The request carries the direction, the row and column addresses, and a flag that marks the target as outside DRAM. A separate one-cycle pulse asks for a refresh. The block drives the active-low strobes and the row/column select. While the row strobe is asserted it puts the row address on `addrOut`, and it switches to the column address for the column strobe state. `busy` covers the whole cycle, and `done` pulses once in the closing state. Software reads and writes the register through a plain write-enable port.

Top module: `dram_cycle_seq`

## Requirements
- R1: The control register holds all eight bits as written, including the reserved bits 6, 3 and 2, and `regRdata` shows it one cycle after the write. `rstN` low clears it to 0x00.
- R2: A high `hwStandby` clears the register to 0x00. It takes priority over a write in the same cycle.
- R3: The precharge field sits in bits 5:4. Codes 00, 01, 10 and 11 give 1, 2, 3 and 4 states with `rasN` and `casN` both high at the start of every DRAM access. These states start in the cycle after acceptance.
- R4: The RAS-to-CAS field sits in bits 1:0. With the default mapping, codes 00, 01, 10 and 11 add 0, 1, 2 and 3 wait states. The number of states with `rasN` low and `casN` high is therefore one plus the wait count, and `addrOut` carries the row address (`muxSel` = 0) during them.
- R5: An access has exactly one state with both strobes low, and `addrOut` carries the column address (`muxSel` = 1) in that state. It is followed by exactly one closing state with both strobes high and `done` = 1, after which the block is idle.
- R6: A refresh runs the same programmed precharge count as an access. It then has one state with `casN` low and `rasN` high, then one state with both strobes low, then the closing `done` state.
- R7: When `refReq` and `reqValid` are both high in the same idle cycle, the refresh sequence runs and the access is dropped.
- R8: A non-DRAM request drives no strobe and closes with its `done` state. One extra idle state (busy, no `done`) comes before that only when all three hold: bit 7 was 1 at acceptance, the request is non-DRAM, and the previous completed cycle was a DRAM read. A DRAM write, a refresh or a non-DRAM access in between clears that condition.
- R9: A register write made while a cycle runs does not change that cycle's timing. The next accepted cycle uses the new value.
- R10: `busy` and `done` are low after reset. `busy` is high from the cycle after acceptance through the `done` state, and low again in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hwStandby | input | 1 | Hardware standby; clears the control register |
| regWe | input | 1 | Control register write enable |
| regWdata | input | 8 | Control register write data |
| regRdata | output | 8 | Control register contents |
| reqValid | input | 1 | Access request pulse |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqNonDram | input | 1 | 1 = access targets non-DRAM space |
| rowAddr | input | ADDR_W | Row address of the request |
| colAddr | input | ADDR_W | Column address of the request |
| refReq | input | 1 | Refresh request pulse |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| muxSel | output | 1 | 0 = row address, 1 = column address |
| addrOut | output | ADDR_W | Multiplexed DRAM address |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle end-of-cycle strobe |

## Verification
The embedded properties assume two things about the inputs. First, `reqValid` and `refReq` arrive only as single-cycle pulses while `busy` is low. Second, register writes never coincide with `hwStandby` unless the clear is meant to win. The stimulus follows both rules: every request is raised on one falling edge and dropped on the next. The bench waits for the closing state and the following idle cycle before it offers anything new. The only register write made during a cycle is the one the snapshot check needs. All counts of precharge, row-to-column and idle states are taken from the strobe ports alone.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int CFG_W   = 8;
  localparam int CNT_W   = 3;
  localparam int IDLE_EN = 7;
  localparam int PRE_HI  = 5;
  localparam int PRE_LO  = 4;
  localparam int RCD_HI  = 1;
  localparam int RCD_LO  = 0;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_ROW,
    S_WAIT,
    S_COL,
    S_CBR_CAS,
    S_CBR_RAS,
    S_GAP,
    S_END
  } seqState_t;

  typedef enum logic [1:0] {
    K_READ,
    K_WRITE,
    K_REFRESH,
    K_OTHER
  } cycleKind_t;

  typedef struct packed {
    logic latchReq;
    logic loadPre;
    logic loadWait;
    logic decCnt;
    logic markRead;
    logic clearRead;
  } seqStrobes_t;

endpackage

// File: rtl/dram_seq_dp.sv
module dram_seq_dp
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter bit RCD_PLUS_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              regWe,
  input  logic [CFG_W-1:0]  regWdata,
  output logic [CFG_W-1:0]  regRdata,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic [ADDR_W-1:0] colAddr,
  input  seqStrobes_t       strobes,
  input  logic              muxSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic              cntZero,
  output logic              waitNone,
  output logic              idleNeeded
);

  logic [CFG_W-1:0]  cfgReg;
  logic [1:0]        snapWait;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  waitCnt;
  logic [ADDR_W-1:0] rowQ;
  logic [ADDR_W-1:0] colQ;
  logic              lastRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (hwStandby) begin
      cfgReg <= '0;
    end else if (regWe) begin
      cfgReg <= regWdata;
    end
  end

  assign regRdata = cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapWait <= '0;
      rowQ     <= '0;
      colQ     <= '0;
    end else if (strobes.latchReq) begin
      snapWait <= cfgReg[RCD_HI:RCD_LO];
      rowQ     <= rowAddr;
      colQ     <= colAddr;
    end
  end

  generate
    if (RCD_PLUS_ONE) begin : gWaitOneBased
      assign waitCnt = CNT_W'(snapWait) + CNT_W'(1);
    end else begin : gWaitZeroBased
      assign waitCnt = CNT_W'(snapWait);
    end
  endgenerate

  assign waitNone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.loadPre) begin
      cnt <= CNT_W'(cfgReg[PRE_HI:PRE_LO]);
    end else if (strobes.loadWait) begin
      cnt <= waitCnt - CNT_W'(1);
    end else if (strobes.decCnt) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastRead <= 1'b0;
    end else if (strobes.markRead) begin
      lastRead <= 1'b1;
    end else if (strobes.clearRead) begin
      lastRead <= 1'b0;
    end
  end

  assign idleNeeded = cfgReg[IDLE_EN] && lastRead;
  assign addrOut    = muxSel ? colQ : rowQ;

  assert_reg_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !hwStandby) |=> (regRdata == $past(regWdata)));

  assert_standby_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (regRdata == '0));

  assert_snapshot_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchReq |=> $stable(snapWait));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decCnt |-> !cntZero);

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqNonDram,
  input  logic        refReq,
  input  logic        cntZero,
  input  logic        waitNone,
  input  logic        idleNeeded,
  output seqStrobes_t strobes,
  output logic        rasN,
  output logic        casN,
  output logic        muxSel,
  output logic        busy,
  output logic        done
);

  seqState_t  state;
  seqState_t  stateNext;
  cycleKind_t kindQ;
  cycleKind_t kindNext;

  always_comb begin
    stateNext = state;
    kindNext  = kindQ;
    strobes   = '0;
    unique case (state)
      S_IDLE: begin
        if (refReq) begin
          strobes.latchReq = 1'b1;
          strobes.loadPre  = 1'b1;
          kindNext         = K_REFRESH;
          stateNext        = S_PRE;
        end else if (reqValid) begin
          strobes.latchReq = 1'b1;
          if (reqNonDram) begin
            kindNext  = K_OTHER;
            stateNext = idleNeeded ? S_GAP : S_END;
          end else begin
            strobes.loadPre = 1'b1;
            kindNext        = reqWrite ? K_WRITE : K_READ;
            stateNext       = S_PRE;
          end
        end
      end
      S_PRE: begin
        if (cntZero) begin
          stateNext = (kindQ == K_REFRESH) ? S_CBR_CAS : S_ROW;
        end else begin
          strobes.decCnt = 1'b1;
        end
      end
      S_ROW: begin
        if (waitNone) begin
          stateNext = S_COL;
        end else begin
          strobes.loadWait = 1'b1;
          stateNext        = S_WAIT;
        end
      end
      S_WAIT: begin
        if (cntZero) begin
          stateNext = S_COL;
        end else begin
          strobes.decCnt = 1'b1;
        end
      end
      S_COL:     stateNext = S_END;
      S_CBR_CAS: stateNext = S_CBR_RAS;
      S_CBR_RAS: stateNext = S_END;
      S_GAP:     stateNext = S_END;
      S_END: begin
        if (kindQ == K_READ) begin
          strobes.markRead = 1'b1;
        end else begin
          strobes.clearRead = 1'b1;
        end
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= K_OTHER;
    end else begin
      state <= stateNext;
      kindQ <= kindNext;
    end
  end

  assign rasN   = !((state == S_ROW) || (state == S_WAIT) || (state == S_COL) ||
                    (state == S_CBR_RAS));
  assign casN   = !((state == S_COL) || (state == S_CBR_CAS) || (state == S_CBR_RAS));
  assign muxSel = (state == S_COL);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_END);

  assert_row_after_pre_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ROW) |-> ($past(state) == S_PRE));

  assert_cas_before_ras_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CBR_RAS) |-> ($past(casN) == 1'b0 && $past(rasN) == 1'b1));

  assert_gap_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP) |=> (state == S_END));

  assert_done_then_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_refresh_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && refReq) |=> (kindQ == K_REFRESH));

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter bit RCD_PLUS_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqNonDram,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic [ADDR_W-1:0] colAddr,
  input  logic              refReq,
  output logic              rasN,
  output logic              casN,
  output logic              muxSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic              busy,
  output logic              done
);

  seqStrobes_t strobes;
  logic        cntZero;
  logic        waitNone;
  logic        idleNeeded;

  dram_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqNonDram (reqNonDram),
    .refReq     (refReq),
    .cntZero    (cntZero),
    .waitNone   (waitNone),
    .idleNeeded (idleNeeded),
    .strobes    (strobes),
    .rasN       (rasN),
    .casN       (casN),
    .muxSel     (muxSel),
    .busy       (busy),
    .done       (done)
  );

  dram_seq_dp #(
    .ADDR_W       (ADDR_W),
    .RCD_PLUS_ONE (RCD_PLUS_ONE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .hwStandby  (hwStandby),
    .regWe      (regWe),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .rowAddr    (rowAddr),
    .colAddr    (colAddr),
    .strobes    (strobes),
    .muxSel     (muxSel),
    .addrOut    (addrOut),
    .cntZero    (cntZero),
    .waitNone   (waitNone),
    .idleNeeded (idleNeeded)
  );

endmodule

// File: tb/tb_dram_cycle_seq.sv
`timescale 1ns/1ps
module tb_dram_cycle_seq;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic          hwStandby;
  logic          regWe;
  logic [7:0]    regWdata;
  logic [7:0]    regRdata;
  logic          reqValid;
  logic          reqWrite;
  logic          reqNonDram;
  logic [AW-1:0] rowAddr;
  logic [AW-1:0] colAddr;
  logic          refReq;
  logic          rasN;
  logic          casN;
  logic          muxSel;
  logic [AW-1:0] addrOut;
  logic          busy;
  logic          done;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dram_cycle_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqNonDram(reqNonDram), .rowAddr(rowAddr),
    .colAddr(colAddr), .refReq(refReq), .rasN(rasN), .casN(casN),
    .muxSel(muxSel), .addrOut(addrOut), .busy(busy), .done(done)
  );

  // [15:8] register value, [7:4] expected precharge states, [3:0] expected waits
  localparam logic [15:0] VEC [8] = '{
    16'h00_10, 16'h01_11, 16'h02_12, 16'h03_13,
    16'h10_20, 16'h21_31, 16'h32_42, 16'h33_43
  };

  int nHigh, nRow, nBoth, nCbr;
  logic [AW-1:0] rowSeen, colSeen;
  logic firstBusy, endClean, idleAfter, finished;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    regWe = 1'b1; regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // kind: 0 read, 1 write, 2 refresh, 3 non-DRAM, 4 refresh+read together
  task automatic runCycle(input int kind, input logic [AW-1:0] r, input logic [AW-1:0] c,
                          input bit midWe, input logic [7:0] midVal);
    @(negedge clk);
    refReq     = (kind == 2 || kind == 4);
    reqValid   = (kind != 2);
    reqWrite   = (kind == 1);
    reqNonDram = (kind == 3);
    rowAddr = r; colAddr = c;
    nHigh = 0; nRow = 0; nBoth = 0; nCbr = 0;
    rowSeen = '0; colSeen = '0; endClean = 1'b0; finished = 1'b0;
    @(negedge clk);
    refReq = 1'b0; reqValid = 1'b0;
    rowAddr = '0; colAddr = '0;
    firstBusy = busy;
    for (int i = 0; i < 40; i++) begin
      if (midWe && i == 0) begin regWe = 1'b1; regWdata = midVal; end
      if (midWe && i == 1) regWe = 1'b0;
      if (done) begin
        endClean = rasN && casN && busy;
        finished = 1'b1;
        break;
      end
      if (busy) begin
        if (rasN && casN) nHigh++;
        else if (!rasN && casN) begin
          if (nRow == 0) rowSeen = addrOut;
          if (muxSel) rowSeen = '1;
          nRow++;
        end else if (!rasN && !casN) begin
          if (muxSel) colSeen = addrOut;
          nBoth++;
        end else nCbr++;
      end
      @(negedge clk);
    end
    regWe = 1'b0;
    @(negedge clk);
    idleAfter = !busy && !done;
    chk(finished, "R10 cycle finished", int'(finished), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; hwStandby = 1'b0; regWe = 1'b0; regWdata = '0;
    reqValid = 1'b0; reqWrite = 1'b0; reqNonDram = 1'b0;
    rowAddr = '0; colAddr = '0; refReq = 1'b0;
    repeat (3) @(negedge clk);
    // reset state: R1, R10
    chk(regRdata == 8'h00, "R1 reset value", regRdata, 0);
    chk(rasN && casN, "R10 strobes idle at reset", {rasN, casN}, 3);
    chk(!busy && !done, "R10 busy/done low at reset", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // register: R1, R2
    writeReg(8'hFF);
    chk(regRdata == 8'hFF, "R1 all bits stored", regRdata, 8'hFF);
    @(negedge clk); hwStandby = 1'b1;
    @(negedge clk); hwStandby = 1'b0;
    chk(regRdata == 8'h00, "R2 standby clear", regRdata, 0);
    writeReg(8'h5A);
    chk(regRdata == 8'h5A, "R1 readback", regRdata, 8'h5A);
    @(negedge clk); hwStandby = 1'b1; regWe = 1'b1; regWdata = 8'hC3;
    @(negedge clk); hwStandby = 1'b0; regWe = 1'b0;
    chk(regRdata == 8'h00, "R2 standby beats write", regRdata, 0);
    writeReg(8'hA5);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk(regRdata == 8'h00, "R1 reset clears", regRdata, 0);

    // table walk: R3, R4, R5, R6
    for (int v = 0; v < 8; v++) begin
      int pre, wt;
      logic [AW-1:0] r, c;
      pre = int'(VEC[v][7:4]);
      wt  = int'(VEC[v][3:0]);
      r = AW'(10'h0A5 + v);
      c = AW'(10'h35A - v);
      writeReg(VEC[v][15:8]);
      runCycle(0, r, c, 1'b0, 8'h00);
      chk(firstBusy, "R10 busy after accept", int'(firstBusy), 1);
      chk(nHigh == pre, "R3 precharge states", nHigh, pre);
      chk(nRow == 1 + wt, "R4 ras-to-cas states", nRow, 1 + wt);
      chk(rowSeen == r, "R4 row address", int'(rowSeen), int'(r));
      chk(nBoth == 1, "R5 cas states", nBoth, 1);
      chk(colSeen == c, "R5 column address", int'(colSeen), int'(c));
      chk(nCbr == 0, "R5 no cas-only state", nCbr, 0);
      chk(endClean, "R5 done state strobes high", int'(endClean), 1);
      chk(idleAfter, "R10 idle after done", int'(idleAfter), 1);
      runCycle(2, '0, '0, 1'b0, 8'h00);
      chk(nHigh == pre, "R6 refresh precharge", nHigh, pre);
      chk(nCbr == 1, "R6 cas-before-ras state", nCbr, 1);
      chk(nBoth == 1, "R6 both low state", nBoth, 1);
      chk(nRow == 0, "R6 no ras-only state", nRow, 0);
      chk(endClean && idleAfter, "R6 refresh close", int'(endClean && idleAfter), 1);
    end

    // snapshot: R9
    writeReg(8'h30);
    runCycle(1, 10'h011, 10'h022, 1'b1, 8'h00);
    chk(nHigh == 4, "R9 running cycle keeps old timing", nHigh, 4);
    chk(regRdata == 8'h00, "R9 write landed", regRdata, 0);
    runCycle(1, 10'h011, 10'h022, 1'b0, 8'h00);
    chk(nHigh == 1, "R9 next cycle uses new timing", nHigh, 1);

    // priority: R7
    writeReg(8'h11);
    runCycle(4, 10'h3FF, 10'h001, 1'b0, 8'h00);
    chk(nCbr == 1 && nRow == 0, "R7 refresh chosen", nCbr * 10 + nRow, 10);
    chk(nHigh == 2, "R7 refresh precharge", nHigh, 2);
    chk(idleAfter, "R7 access dropped", int'(idleAfter), 1);

    // idle insertion: R8
    writeReg(8'h80);
    runCycle(0, 10'h040, 10'h080, 1'b0, 8'h00);
    runCycle(3, 10'h000, 10'h000, 1'b0, 8'h00);
    chk(nHigh == 1, "R8 idle after dram read", nHigh, 1);
    chk(nRow + nBoth + nCbr == 0, "R8 no strobes on non-DRAM", nRow + nBoth + nCbr, 0);
    chk(endClean && idleAfter, "R8 non-DRAM close", int'(endClean && idleAfter), 1);
    runCycle(3, 10'h000, 10'h000, 1'b0, 8'h00);
    chk(nHigh == 0, "R8 no idle after non-DRAM", nHigh, 0);
    runCycle(1, 10'h040, 10'h080, 1'b0, 8'h00);
    runCycle(3, 10'h000, 10'h000, 1'b0, 8'h00);
    chk(nHigh == 0, "R8 no idle after dram write", nHigh, 0);
    runCycle(0, 10'h040, 10'h080, 1'b0, 8'h00);
    runCycle(2, 10'h000, 10'h000, 1'b0, 8'h00);
    runCycle(3, 10'h000, 10'h000, 1'b0, 8'h00);
    chk(nHigh == 0, "R8 refresh clears read mark", nHigh, 0);
    writeReg(8'h00);
    runCycle(0, 10'h040, 10'h080, 1'b0, 8'h00);
    runCycle(3, 10'h000, 10'h000, 1'b0, 8'h00);
    chk(nHigh == 0, "R8 idle disabled", nHigh, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule